// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume Register

This block stores the 6-bit gain codes of one stereo gain stage and decides the cycle in which a newly programmed code becomes the active code seen by the audio path. Each channel has two stages. A write fills that channel's pending stage. A shared update request then copies both pending codes into a latched target. With zero-cross gating off, the target goes live at once. With gating on, each channel waits until its own sample stream passes through zero. A slow timeout tick ends the wait if no crossing comes.

The gain code runs from 0 (-12 dB) to 63 (+35.25 dB) in 0.75 dB steps, and code 16 is 0 dB. Code-to-gain conversion and the analogue stage are outside the block. A per-channel mute flag is written along with each gain write. Mute silences the stage and leaves the stored codes as they are. The timeout tick is expected to come from a divider of 2^21 master-clock cycles. It is counted only while the slow-clock enable is high, so a forced update lands between one and two tick periods after the request.

Top module: `zcv_gain_reg`

## Requirements
- R1: After reset both active gain codes are 16 (0 dB), both pending codes are 16, both mute flags are 0 and no update is waiting.
- R2: A write with `wr_upd` low stores `wr_gain` in the pending stage of channel `wr_ch` and leaves both active codes unchanged.
- R3: A write with `wr_upd` high while `zc_en` is low makes both active codes equal to their pending codes, including the value carried by that same write, at the next clock edge.
- R4: A write with `wr_upd` high while `zc_en` is high latches both pending codes as targets. Each channel independently takes its target at the edge of its first valid sample that crosses zero. A crossing is a sample equal to zero, or a sample whose sign bit differs from that channel's previous valid sample. The first valid sample after reset counts only if it is zero.
- R5: A waiting update is forced on both waiting channels at the second enabled tick (`slow_tick` and `slow_en` both high) after the request. Ticks while `slow_en` is low are not counted.
- R6: A new update request that arrives while an update is waiting restarts the tick count and replaces both targets with the newest pending codes.
- R7: Every write sets the mute flag of channel `wr_ch` to `wr_mute` at the next edge and does not alter any active gain code.
- R8: Samples presented while `samp_valid` is low neither complete an update nor change the remembered sign.
- R9: When an update request and a zero crossing fall in the same cycle, the request wins: the wait restarts with the new targets and the crossing completes nothing.
- R10: Channel 0 (left) is `wr_ch` = 0 and uses the low slice of `samp_data` and `gain_out` and bit 0 of `mute_out`. Channel 1 (right) is `wr_ch` = 1 and uses the upper slice and bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | CHW (1) | Channel written: 0 left, 1 right |
| wr_gain | input | GW (6) | Gain code for the pending stage |
| wr_mute | input | 1 | Mute flag for the written channel |
| wr_upd | input | 1 | Update request carried by the write |
| zc_en | input | 1 | Zero-cross gating for requests made now |
| slow_en | input | 1 | Enables counting of timeout ticks |
| slow_tick | input | 1 | One-cycle slow timeout tick |
| samp_valid | input | 1 | Sample strobe for both channels |
| samp_data | input | NCH*SW (32) | Signed samples, channel 0 in the low slice |
| gain_out | output | NCH*GW (12) | Active gain codes, channel 0 in the low slice |
| mute_out | output | NCH (2) | Mute flags per channel |

## Verification
Two functions can fall in the same cycle. The first pair is an update request and a zero crossing: the bench issues a new gated request in the very cycle that a sign change arrives on the left channel. It expects the old code to stay, then to be replaced at the next crossing by the newest target. The second pair is a timeout tick and a crossing: the bench puts the second enabled tick in the cycle where the right channel sees a zero sample. It expects both channels to take their targets once, in the same edge, with no leftover wait.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  localparam int GAIN_W       = 6;
  localparam int GAIN_RST     = 16;  // 0 dB
  localparam int FORCE_TICKS  = 2;   // forced update on this tick after the request
endpackage

// File: rtl/zcv_xing_detect.sv
module zcv_xing_detect #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [SW-1:0] sample,
  output logic          xing
);
  logic prev_sign;
  logic have_prev;
  logic is_zero;

  assign is_zero = (sample == '0);
  assign xing    = valid && (is_zero || (have_prev && (sample[SW-1] != prev_sign)));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sign <= 1'b0;
      have_prev <= 1'b0;
    end else if (valid) begin
      prev_sign <= sample[SW-1];
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/zcv_timeout.sv
module zcv_timeout #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic any_wait,
  input  logic tick_en,
  output logic fire
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign fire = any_wait && tick_en && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !any_wait) begin
      cnt <= '0;
    end else if (tick_en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/zcv_chan_gain.sv
module zcv_chan_gain #(
  parameter int GW       = 6,
  parameter int RST_GAIN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_wr,
  input  logic [GW-1:0] wr_gain,
  input  logic          wr_mute,
  input  logic          upd,
  input  logic          zc_en,
  input  logic          xing,
  input  logic          fire,
  output logic          waiting,
  output logic [GW-1:0] gain,
  output logic          mute
);
  logic [GW-1:0] pend_q;
  logic [GW-1:0] pend_nx;
  logic [GW-1:0] tgt_q;

  assign pend_nx = sel_wr ? wr_gain : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= GW'(RST_GAIN);
      tgt_q   <= GW'(RST_GAIN);
      gain    <= GW'(RST_GAIN);
      waiting <= 1'b0;
      mute    <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      if (sel_wr) mute <= wr_mute;
      if (upd) begin
        if (zc_en) begin
          tgt_q   <= pend_nx;
          waiting <= 1'b1;
        end else begin
          gain    <= pend_nx;
          waiting <= 1'b0;
        end
      end else if (waiting && (xing || fire)) begin
        gain    <= tgt_q;
        waiting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/zcv_gain_reg.sv
module zcv_gain_reg #(
  parameter int NCH      = 2,
  parameter int SW       = 16,
  parameter int GW       = zcv_pkg::GAIN_W,
  parameter int RST_GAIN = zcv_pkg::GAIN_RST,
  parameter int TICKS    = zcv_pkg::FORCE_TICKS,
  parameter int CHW      = (NCH < 2) ? 1 : $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [GW-1:0]     wr_gain,
  input  logic              wr_mute,
  input  logic              wr_upd,
  input  logic              zc_en,
  input  logic              slow_en,
  input  logic              slow_tick,
  input  logic              samp_valid,
  input  logic [NCH*SW-1:0] samp_data,
  output logic [NCH*GW-1:0] gain_out,
  output logic [NCH-1:0]    mute_out
);
  logic           upd;
  logic           fire;
  logic [NCH-1:0] wait_q;
  logic [NCH-1:0] xing;

  assign upd = wr_en && wr_upd;

  zcv_timeout #(.TICKS(TICKS)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .restart  (upd),
    .any_wait (|wait_q),
    .tick_en  (slow_tick && slow_en),
    .fire     (fire)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zcv_xing_detect #(.SW(SW)) u_xd (
      .clk    (clk),
      .rst    (rst),
      .valid  (samp_valid),
      .sample (samp_data[c*SW +: SW]),
      .xing   (xing[c])
    );

    zcv_chan_gain #(.GW(GW), .RST_GAIN(RST_GAIN)) u_cg (
      .clk     (clk),
      .rst     (rst),
      .sel_wr  (wr_en && (wr_ch == CHW'(c))),
      .wr_gain (wr_gain),
      .wr_mute (wr_mute),
      .upd     (upd),
      .zc_en   (zc_en),
      .xing    (xing[c]),
      .fire    (fire),
      .waiting (wait_q[c]),
      .gain    (gain_out[c*GW +: GW]),
      .mute    (mute_out[c])
    );
  end
endmodule

// File: rtl/zcv_gain_reg_chk.sv
module zcv_gain_reg_chk #(
  parameter int NCH = 2,
  parameter int GW  = 6,
  parameter int CHW = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CHW-1:0]    wr_ch,
  input logic [GW-1:0]     wr_gain,
  input logic              wr_mute,
  input logic              wr_upd,
  input logic              zc_en,
  input logic [NCH*GW-1:0] gain_out,
  input logic [NCH-1:0]    mute_out,
  input logic [NCH-1:0]    wait_q,
  input logic [NCH-1:0]    xing,
  input logic              fire
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && wr_upd) && !wait_q[c]) |=> $stable(gain_out[c*GW +: GW])); // R2
    AST_DIRECT_UPD: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_upd && !zc_en && (wr_ch == CHW'(c))) |=> (gain_out[c*GW +: GW] == $past(wr_gain))); // R3
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wait_q[c] && !(wr_en && wr_upd) && !xing[c] && !fire) |=> $stable(gain_out[c*GW +: GW])); // R4
    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (fire && !(wr_en && wr_upd)) |=> !wait_q[c]); // R5
    AST_REQ_ARMS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_upd && zc_en) |=> wait_q[c]); // R6
    AST_MUTE_WR: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_ch == CHW'(c))) |=> (mute_out[c] == $past(wr_mute))); // R7
  end
endmodule

bind zcv_gain_reg zcv_gain_reg_chk #(.NCH(NCH), .GW(GW), .CHW(CHW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_ch    (wr_ch),
  .wr_gain  (wr_gain),
  .wr_mute  (wr_mute),
  .wr_upd   (wr_upd),
  .zc_en    (zc_en),
  .gain_out (gain_out),
  .mute_out (mute_out),
  .wait_q   (wait_q),
  .xing     (xing),
  .fire     (fire)
);

// File: tb/test_zcv_gain_reg.sv
module test_zcv_gain_reg;
  localparam int NV = 28;
  localparam logic [15:0] P = 16'h0064;
  localparam logic [15:0] N = 16'hFF9C;
  localparam logic [15:0] Z = 16'h0000;

  typedef struct packed {
    logic       we;
    logic       ch;
    logic [5:0] g;
    logic       m;
    logic       u;
    logic       zc;
    logic       se;
    logic       tk;
    logic       sv;
    logic [15:0] sl;
    logic [15:0] sr;
    logic [5:0] el;
    logic [5:0] er;
    logic [1:0] em;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    {1'b1,1'b0,6'd20,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd16,6'd16,2'b00,4'd2},  // R2
    {1'b1,1'b1,6'd30,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd16,6'd16,2'b00,4'd2},  // R2 R10
    {1'b1,1'b0,6'd21,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd21,6'd30,2'b00,4'd3},  // R3
    {1'b1,1'b1,6'd40,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd21,6'd30,2'b00,4'd2},
    {1'b1,1'b0,6'd10,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd21,6'd30,2'b00,4'd4},  // R4 request
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,P,P,6'd21,6'd30,2'b00,4'd4},  // R4 first sample
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,P,N,6'd21,6'd40,2'b00,4'd4},  // R4 right crosses
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,N,N,6'd21,6'd40,2'b00,4'd8},  // R8
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,Z,N,6'd10,6'd40,2'b00,4'd4},  // R4 zero sample
    {1'b1,1'b1,6'd50,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd10,6'd40,2'b00,4'd5},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd10,6'd40,2'b00,4'd5},  // R5 tick 1
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,P,N,6'd10,6'd50,2'b00,4'd5},  // R5 tick 2
    {1'b1,1'b0,6'd12,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd10,6'd50,2'b00,4'd6},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd10,6'd50,2'b00,4'd6},
    {1'b1,1'b0,6'd13,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd10,6'd50,2'b00,4'd6},  // R6 restart
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd10,6'd50,2'b00,4'd6},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd13,6'd50,2'b00,4'd6},
    {1'b1,1'b1,6'd50,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd13,6'd50,2'b10,4'd7},  // R7
    {1'b1,1'b0,6'd14,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd13,6'd50,2'b10,4'd5},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,Z,Z,6'd13,6'd50,2'b10,4'd5},  // R5 disabled tick
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,Z,Z,6'd13,6'd50,2'b10,4'd5},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd13,6'd50,2'b10,4'd5},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z,6'd14,6'd50,2'b10,4'd5},
    {1'b1,1'b0,6'd15,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z,6'd14,6'd50,2'b10,4'd9},
    {1'b1,1'b0,6'd17,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,N,N,6'd14,6'd50,2'b10,4'd9},  // R9 collision
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,N,N,6'd14,6'd50,2'b10,4'd9},
    {1'b0,1'b0,6'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,P,N,6'd17,6'd50,2'b10,4'd9},
    {1'b1,1'b1,6'd50,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z,6'd17,6'd50,2'b00,4'd7}   // R7 clear
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_ch = 1'b0, wr_mute = 1'b0, wr_upd = 1'b0;
  logic [5:0]  wr_gain = '0;
  logic        zc_en = 1'b0, slow_en = 1'b1, slow_tick = 1'b0, samp_valid = 1'b0;
  logic [31:0] samp_data = '0;
  logic [11:0] gain_out;
  logic [1:0]  mute_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zcv_gain_reg i_zcv_gain_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_gain(wr_gain),
    .wr_mute(wr_mute), .wr_upd(wr_upd), .zc_en(zc_en), .slow_en(slow_en),
    .slow_tick(slow_tick), .samp_valid(samp_valid), .samp_data(samp_data),
    .gain_out(gain_out), .mute_out(mute_out)
  );

  task automatic check(input string tag, input logic [5:0] el, input logic [5:0] er,
                       input logic [1:0] em);
    n_chk++;
    if (gain_out !== {er, el} || mute_out !== em) begin
      n_bad++;
      $display("FAIL %s: got L=%0d R=%0d mute=%b, expected L=%0d R=%0d mute=%b",
               tag, gain_out[5:0], gain_out[11:6], mute_out, el, er, em);
    end
  endtask

  task automatic drive(input logic we, input logic ch, input logic [5:0] g, input logic m,
                       input logic u, input logic zc, input logic se, input logic tk,
                       input logic sv, input logic [15:0] sl, input logic [15:0] sr);
    wr_en = we; wr_ch = ch; wr_gain = g; wr_mute = m; wr_upd = u; zc_en = zc;
    slow_en = se; slow_tick = tk; samp_valid = sv; samp_data = {sr, sl};
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,Z,Z);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset", 6'd16, 6'd16, 2'b00); // R1

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].we, TBL[i].ch, TBL[i].g, TBL[i].m, TBL[i].u, TBL[i].zc,
            TBL[i].se, TBL[i].tk, TBL[i].sv, TBL[i].sl, TBL[i].sr);
      check($sformatf("R%0d vec %0d", TBL[i].rq, i), TBL[i].el, TBL[i].er, TBL[i].em);
    end

    // R1: reset while an update waits discards it
    @(negedge clk);
    drive(1'b1,1'b0,6'd33,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z);
    @(negedge clk);
    rst = 1'b1;
    idle();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset mid-wait", 6'd16, 6'd16, 2'b00);
    @(negedge clk);
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z);
    @(negedge clk);
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z);
    check("R5 ticks with nothing waiting", 6'd16, 6'd16, 2'b00);

    // R5 with R4: second tick and right zero crossing in the same cycle
    @(negedge clk);
    drive(1'b1,1'b1,6'd44,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,Z,Z);
    check("R4 request armed", 6'd16, 6'd16, 2'b00);
    @(negedge clk);
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,Z,Z);
    check("R5 first tick holds", 6'd16, 6'd16, 2'b00);
    @(negedge clk);
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,P,Z);
    check("R5 tick with crossing", 6'd16, 6'd44, 2'b00);
    @(negedge clk);
    drive(1'b0,1'b0,6'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,N,N);
    check("R5 no second update", 6'd16, 6'd44, 2'b00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule